// File: doc/BRIEF.md
# ACPI Sleep-State Power Sequencer

This block is the digital control core of a multi-rail memory and chipset power supply. It watches two active-low sleep-state inputs (S3 request and S5 request) and two supply power-on-reset flags (standby and 12 V). From these it drives enable lines for five regulator rails, a reset for the switching error amplifiers, a reference-short control for the memory termination regulator, and an open-drain power-good pull-down. The analog regulators and their comparators are outside the block. Each rail reports back through an in-regulation flag.

On a start from shutdown, the block first holds the error amplifiers in reset for three soft-start cycles. It then brings the rails up one stage at a time, and each stage waits for the previous rail's in-regulation flag. The stages are the memory supply rail (index 0), then the chipset core rail (index 1), then the chipset/CPU termination rail (index 2) together with the I/O LDO rail (index 3), then the memory termination rail (index 4). One soft-start cycle after the last enable, the power-good comparator is armed.

In S3 only the memory supply rail stays on. On a resume to S0, the bring-up is repeated without the memory supply stage. The sleep and POR inputs pass through a two-flop synchroniser. The rail flags are taken as synchronous to `clk`.

States (the `state_code` values in brackets):
- OFF [0]
- AMP_RST [1]
- RAMP_MEM [2]
- RAMP_CORE [3]
- RAMP_TERM [4]
- RAMP_MTT [5]
- ACTIVE [6]
- SLEEP [7]

Transitions:
- OFF→AMP_RST when both sleep inputs are high and both POR flags are set.
- AMP_RST→RAMP_MEM at the end of the reset window, if the memory rail is off.
- AMP_RST→RAMP_CORE at the end of the reset window, if the memory rail is already on.
- RAMP_MEM→RAMP_CORE on rail 0 ok.
- RAMP_CORE→RAMP_TERM on rail 1 ok.
- RAMP_TERM→RAMP_MTT on rails 2 and 3 ok.
- RAMP_MTT→ACTIVE after one soft-start cycle.
- Any S0-side state (AMP_RST through ACTIVE)→SLEEP when S3 is requested or 12 V POR is lost.
- SLEEP→AMP_RST when S0 is requested and 12 V POR is present.
- Any state→OFF when S5 is requested or standby POR is lost.

Top module: `acpi_power_sequencer`

## Requirements
- R1: After reset, and while in OFF, `rail_en` is 0, `pgood_pull_low` is 1, `vtt_ref_short` is 1 and `state_code` is 0. OFF is left only when both sleep inputs are high and both POR flags are set.
- R2: Leaving OFF or SLEEP enters AMP_RST. AMP_RST lasts exactly RESET_SS×SS_CYCLES clocks, with `amp_reset` high and rails 1 to 4 disabled.
- R3: On a start from OFF, rail 0 is enabled alone first (RAMP_MEM). Rail 1 is enabled only after `rail_ok[0]` is seen. No higher rail is ever enabled while a lower-stage rail is off.
- R4: Rails 2 and 3 are enabled on the same clock, after `rail_ok[1]`. Rail 4 is enabled only once both `rail_ok[2]` and `rail_ok[3]` are high.
- R5: ACTIVE is entered exactly SS_CYCLES clocks after rail 4 is enabled. In ACTIVE, `pgood_pull_low` is the inverse of `rail_ok[2]`, with no clock delay.
- R6: In SLEEP (S3 requested while S5 is not), only rail 0 stays enabled, and then only if it was on before. `pgood_pull_low` is 1.
- R7: `vtt_ref_short` is 1 whenever rail 4 is disabled and 0 whenever it is enabled.
- R8: Leaving SLEEP repeats AMP_RST with rail 0 kept on throughout. Bring-up then continues at RAMP_CORE, skipping RAMP_MEM.
- R9: S5 requested, or standby POR lost, moves any state to OFF, with all rails disabled and power-good pulled low.
- R10: `pgood_pull_low` is 1 in every state other than ACTIVE.
- R11: Loss of the 12 V POR flag in any S0-side state moves to SLEEP, keeping rail 0. Bring-up restarts through AMP_RST when the flag returns.
- R12: `state_code` encodes OFF=0, AMP_RST=1, RAMP_MEM=2, RAMP_CORE=3, RAMP_TERM=4, RAMP_MTT=5, ACTIVE=6, SLEEP=7. `rail_en` and `rail_ok` bit i is rail i, with rails numbered as in the order above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock (soft-start time base) |
| rst_n | input | 1 | Asynchronous active-low reset |
| slp_s3_n | input | 1 | Active-low S3 sleep request, asynchronous |
| slp_s5_n | input | 1 | Active-low S5 shutdown request, asynchronous |
| sby_por_ok | input | 1 | Standby supply above POR threshold, asynchronous |
| p12_por_ok | input | 1 | 12 V supply above POR threshold, asynchronous |
| rail_ok | input | 5 | Per-rail in-regulation flags, synchronous |
| rail_en | output | 5 | Per-rail enable |
| amp_reset | output | 1 | Error amplifier reset (output shorted to feedback) |
| vtt_ref_short | output | 1 | Short memory termination reference to its output |
| pgood_pull_low | output | 1 | 1 = open-drain power-good driven low, 0 = released |
| state_code | output | 3 | Encoded sequencer state |

## Verification
The bench measures the length of the amplifier-reset window and of the power-good arming delay in clocks. An off-by-one timer compare would show up as a window one cycle too short or too long. It holds back individual in-regulation flags, for example raising rail 2 without rail 3, to catch a design that advances on a partial condition or enables rails 2 and 3 on different clocks. Across S3 entry, resume and a 12 V dropout, it checks that rail 0 never drops and that RAMP_MEM is skipped. A design that cleared the memory rail in sleep, or restarted from RAMP_MEM, would glitch the memory supply. Finally, a shutdown and a standby-POR loss must clear everything, and the following cold start must once more begin at RAMP_MEM.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int NUM_RAILS = 5;
    localparam int RAIL_MEM  = 0;
    localparam int RAIL_CORE = 1;
    localparam int RAIL_TERM = 2;
    localparam int RAIL_IO   = 3;
    localparam int RAIL_MTT  = 4;

    typedef enum logic [2:0] {
        ST_OFF       = 3'd0,
        ST_AMP_RST   = 3'd1,
        ST_RAMP_MEM  = 3'd2,
        ST_RAMP_CORE = 3'd3,
        ST_RAMP_TERM = 3'd4,
        ST_RAMP_MTT  = 3'd5,
        ST_ACTIVE    = 3'd6,
        ST_SLEEP     = 3'd7
    } seq_state_e;
endpackage

// File: rtl/seq_in_sync.sv
module seq_in_sync #(
    parameter int W = 4,
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [N];

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg[g] <= '0;
                end else begin
                    if (g == 0) stg[g] <= d;
                    else        stg[g] <= stg[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign q = stg[N-1];
endmodule

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [CW-1:0] limit,
    output logic          done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt <= '0;
        else if (clr)           cnt <= '0;
        else if (cnt != '1)     cnt <= cnt + 1'b1;
    end

    assign done = (cnt == limit);
endmodule

// File: rtl/seq_outputs.sv
module seq_outputs
    import seq_pkg::*;
(
    input  seq_state_e             state,
    input  logic                   mem_on,
    input  logic                   term_ok,
    output logic [NUM_RAILS-1:0]   rail_en,
    output logic                   amp_reset,
    output logic                   vtt_ref_short,
    output logic                   pgood_pull_low
);
    always_comb begin
        rail_en          = '0;
        rail_en[RAIL_MEM] = mem_on;
        amp_reset        = 1'b0;
        pgood_pull_low   = 1'b1;
        unique case (state)
            ST_OFF:       rail_en = '0;
            ST_AMP_RST:   amp_reset = 1'b1;
            ST_RAMP_MEM:  ;
            ST_RAMP_CORE: rail_en[RAIL_CORE] = 1'b1;
            ST_RAMP_TERM: begin
                rail_en[RAIL_CORE] = 1'b1;
                rail_en[RAIL_TERM] = 1'b1;
                rail_en[RAIL_IO]   = 1'b1;
            end
            ST_RAMP_MTT:  rail_en[NUM_RAILS-1:1] = '1;
            ST_ACTIVE: begin
                rail_en[NUM_RAILS-1:1] = '1;
                pgood_pull_low = !term_ok;
            end
            ST_SLEEP:     ;
            default:      rail_en = '0;
        endcase
        vtt_ref_short = !rail_en[RAIL_MTT];
    end
endmodule

// File: rtl/acpi_power_sequencer.sv
module acpi_power_sequencer
    import seq_pkg::*;
#(
    parameter int SS_CYCLES   = 2048,
    parameter int RESET_SS    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 slp_s3_n,
    input  logic                 slp_s5_n,
    input  logic                 sby_por_ok,
    input  logic                 p12_por_ok,
    input  logic [NUM_RAILS-1:0] rail_ok,
    output logic [NUM_RAILS-1:0] rail_en,
    output logic                 amp_reset,
    output logic                 vtt_ref_short,
    output logic                 pgood_pull_low,
    output logic [2:0]           state_code
);
    localparam int RST_LEN = RESET_SS * SS_CYCLES;
    localparam int CW      = $clog2(RST_LEN + 1);
    localparam logic [CW-1:0] RST_LIM = CW'(RST_LEN - 1);
    localparam logic [CW-1:0] SS_LIM  = CW'(SS_CYCLES - 1);

    logic [3:0] sync_q;
    logic s3_n, s5_n, sby_ok, p12_ok;

    seq_in_sync #(.W(4), .N(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({slp_s3_n, slp_s5_n, sby_por_ok, p12_por_ok}),
        .q     (sync_q)
    );
    assign {s3_n, s5_n, sby_ok, p12_ok} = sync_q;

    seq_state_e    state, nxt;
    logic          mem_on;
    logic          tmr_done;
    logic [CW-1:0] tmr_lim;

    assign tmr_lim = (state == ST_AMP_RST) ? RST_LIM : SS_LIM;

    seq_timer #(.CW(CW)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (nxt != state),
        .limit (tmr_lim),
        .done  (tmr_done)
    );

    // next-state decode
    always_comb begin
        nxt = state;
        if (!sby_ok || !s5_n) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF, ST_SLEEP: if (s3_n && p12_ok) nxt = ST_AMP_RST;
                ST_AMP_RST, ST_RAMP_MEM, ST_RAMP_CORE,
                ST_RAMP_TERM, ST_RAMP_MTT, ST_ACTIVE: begin
                    if (!s3_n || !p12_ok) begin
                        nxt = ST_SLEEP;
                    end else begin
                        unique case (state)
                            ST_AMP_RST:   if (tmr_done) nxt = mem_on ? ST_RAMP_CORE : ST_RAMP_MEM;
                            ST_RAMP_MEM:  if (rail_ok[RAIL_MEM]) nxt = ST_RAMP_CORE;
                            ST_RAMP_CORE: if (rail_ok[RAIL_CORE]) nxt = ST_RAMP_TERM;
                            ST_RAMP_TERM: if (rail_ok[RAIL_TERM] && rail_ok[RAIL_IO]) nxt = ST_RAMP_MTT;
                            ST_RAMP_MTT:  if (tmr_done) nxt = ST_ACTIVE;
                            default:      nxt = state;
                        endcase
                    end
                end
                default: nxt = ST_OFF;
            endcase
        end
    end

    // state register and memory-rail latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_OFF;
            mem_on <= 1'b0;
        end else begin
            state <= nxt;
            if (nxt == ST_OFF)           mem_on <= 1'b0;
            else if (nxt == ST_RAMP_MEM) mem_on <= 1'b1;
        end
    end

    seq_outputs u_out (
        .state          (state),
        .mem_on         (mem_on),
        .term_ok        (rail_ok[RAIL_TERM]),
        .rail_en        (rail_en),
        .amp_reset      (amp_reset),
        .vtt_ref_short  (vtt_ref_short),
        .pgood_pull_low (pgood_pull_low)
    );

    assign state_code = state;
endmodule

// File: rtl/seq_checker.sv
module seq_checker
    import seq_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_RAILS-1:0] rail_en,
    input logic [NUM_RAILS-1:0] rail_ok,
    input logic                 amp_reset,
    input logic                 vtt_ref_short,
    input logic                 pgood_pull_low,
    input logic [2:0]           state_code
);
    // R10
    pg_only_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pgood_pull_low |-> state_code == 3'(ST_ACTIVE));

    // R3
    core_needs_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rail_en[RAIL_CORE] |-> rail_en[RAIL_MEM]);

    // R4
    mtt_needs_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rail_en[RAIL_MTT] |-> (rail_en[RAIL_TERM] && rail_en[RAIL_IO] && rail_en[RAIL_CORE]));

    // R4
    term_io_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rail_en[RAIL_TERM] == rail_en[RAIL_IO]);

    // R2
    amp_rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        amp_reset |-> rail_en[NUM_RAILS-1:1] == '0);

    // R6
    sleep_mem_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_code == 3'(ST_SLEEP) |-> (rail_en[NUM_RAILS-1:1] == '0 && pgood_pull_low));

    // R9
    off_all_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_code == 3'(ST_OFF) |-> (rail_en == '0 && pgood_pull_low && vtt_ref_short));

    // R5
    active_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_code == 3'(ST_ACTIVE)) |-> $past(state_code) == 3'(ST_RAMP_MTT));

    // R8
    resume_keeps_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'(ST_AMP_RST) && rail_en[RAIL_MEM]) |=> state_code != 3'(ST_RAMP_MEM));

    // R4
    mtt_after_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rail_en[RAIL_MTT]) |-> $past(rail_ok[RAIL_TERM] && rail_ok[RAIL_IO]));
endmodule

bind acpi_power_sequencer seq_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rail_en        (rail_en),
    .rail_ok        (rail_ok),
    .amp_reset      (amp_reset),
    .vtt_ref_short  (vtt_ref_short),
    .pgood_pull_low (pgood_pull_low),
    .state_code     (state_code)
);

// File: tb/sim_acpi_power_sequencer.sv
`timescale 1ns/1ps
module sim_acpi_power_sequencer;
    localparam int SS = 32;
    localparam int RS = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       s3n = 1'b0, s5n = 1'b0, sby = 1'b0, p12 = 1'b0;
    logic [4:0] ok = '0;
    logic [4:0] en;
    logic       amp, vshort, pglow;
    logic [2:0] st;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    acpi_power_sequencer #(.SS_CYCLES(SS), .RESET_SS(RS), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .slp_s3_n(s3n), .slp_s5_n(s5n),
        .sby_por_ok(sby), .p12_por_ok(p12), .rail_ok(ok), .rail_en(en),
        .amp_reset(amp), .vtt_ref_short(vshort), .pgood_pull_low(pglow),
        .state_code(st)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_state(input int s, input int maxc, output bit hit);
        hit = 0;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (st == 3'(s)) begin
                hit = 1;
                break;
            end
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 reset state", st, 0);
        chk("R1 reset rails", en, 0);
        chk("R1 reset pg", pglow, 1);
        chk("R7 reset short", vshort, 1);
        chk("R1 reset amp", amp, 0);
    endtask

    task automatic t_hold();
        sby = 1; s5n = 1; s3n = 1; p12 = 0;
        repeat (20) @(negedge clk);
        chk("R1 hold without 12V", st, 0);
        chk("R10 pg in OFF", pglow, 1);
    endtask

    task automatic t_cold();
        bit hit;
        int n;
        bit bad;
        p12 = 1;
        wait_state(1, 10, hit);
        chk("R2 amp reset entered", hit, 1);
        n = 0; bad = 0;
        while (st == 3'd1) begin
            if (!amp || en != 0) bad = 1;
            n++;
            @(negedge clk);
        end
        chk("R2 reset window length", n, RS*SS);
        chk("R2 quiet during reset", bad, 0);
        chk("R3 first stage RAMP_MEM", st, 2);
        chk("R3 only mem enabled", en, 5'b00001);
        repeat (10) @(negedge clk);
        chk("R3 waits for rail0 ok", st, 2);
        ok[0] = 1;
        @(negedge clk);
        chk("R3 core after mem ok", en, 5'b00011);
        chk("R12 RAMP_CORE code", st, 3);
        repeat (5) @(negedge clk);
        ok[1] = 1;
        @(negedge clk);
        chk("R4 term and io together", en, 5'b01111);
        chk("R7 short while mtt off", vshort, 1);
        ok[2] = 1;
        repeat (10) @(negedge clk);
        chk("R4 waits for rail3 ok", st, 4);
        ok[3] = 1;
        @(negedge clk);
        chk("R4 mtt enabled", en, 5'b11111);
        chk("R7 short released", vshort, 0);
        chk("R10 pg low in RAMP_MTT", pglow, 1);
        n = 0;
        while (st == 3'd5) begin
            n++;
            @(negedge clk);
        end
        chk("R5 arming delay", n, SS);
        chk("R5 ACTIVE reached", st, 6);
        chk("R5 pg released", pglow, 0);
        ok[4] = 1;
        ok[2] = 0;
        #1;
        chk("R5 pg follows term ok", pglow, 1);
        ok[2] = 1;
        #1;
        chk("R5 pg released again", pglow, 0);
    endtask

    task automatic t_sleep();
        bit hit;
        s3n = 0;
        wait_state(7, 10, hit);
        chk("R6 SLEEP entered", hit, 1);
        chk("R6 mem only", en, 5'b00001);
        chk("R6 pg low", pglow, 1);
        chk("R7 short in sleep", vshort, 1);
    endtask

    task automatic t_resume(input string tag);
        bit hit;
        bit bad;
        wait_state(1, 10, hit);
        chk({tag, " R8 reset repeated"}, hit, 1);
        bad = 0;
        while (st == 3'd1) begin
            if (en[0] != 1) bad = 1;
            @(negedge clk);
        end
        chk({tag, " R8 mem kept on"}, bad, 0);
        chk({tag, " R8 RAMP_MEM skipped"}, st, 3);
        wait_state(6, 4*SS, hit);
        chk({tag, " R8 back to ACTIVE"}, hit, 1);
    endtask

    task automatic t_p12_loss();
        bit hit;
        p12 = 0;
        wait_state(7, 10, hit);
        chk("R11 12V loss to SLEEP", hit, 1);
        chk("R11 mem kept", en, 5'b00001);
        p12 = 1;
        t_resume("R11");
    endtask

    task automatic t_off();
        bit hit;
        s5n = 0;
        wait_state(0, 10, hit);
        chk("R9 S5 to OFF", hit, 1);
        chk("R9 rails off", en, 0);
        chk("R9 pg low", pglow, 1);
        s5n = 1;
        wait_state(1, 10, hit);
        while (st == 3'd1) @(negedge clk);
        chk("R9 cold restart from RAMP_MEM", st, 2);
        wait_state(6, 4*SS, hit);
        chk("R9 up again", hit, 1);
        sby = 0;
        wait_state(0, 10, hit);
        chk("R9 standby loss to OFF", hit, 1);
        chk("R9 rails off after standby loss", en, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_hold();
        t_cold();
        t_sleep();
        s3n = 1;
        t_resume("S3");
        t_p12_loss();
        t_off();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule